// File: doc/BRIEF.md
# DRAM Hole Remapping Address Decoder

This block sits on the request path of one memory node. For each valid 40-bit physical request address it decides whether the address belongs to the node's local DRAM, falls into the memory-mapped I/O window just below 4 GB, or has no target on this node. For local DRAM it also gives the address relative to the start of the node's DRAM, which a memory controller can use directly. The decision and the translated address appear one clock after the request, together with a valid flag.

Five configuration fields are loaded through a small write port: a DRAM base and an inclusive DRAM limit in 16 MB granules (address bits 39:24), a hole base granule (address bits 31:24), a hole offset granule (bits 31:24) and a hole enable bit. With the hole enabled, every address from the hole base up to 4 GB minus 1 goes to I/O. DRAM that the hole covers is then reached above 4 GB: software widens the limit by the hole size and sets the offset to (0x100 minus hole base) plus base bits 31:24, and the decoder subtracts that offset from addresses at or above 4 GB.

Top module: `dram_hole_decoder`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, rsp_valid is 0, rsp_target is 0 and rsp_dram_addr is 0; reset sets all five configuration fields to zero, so with no write a request in granule 0 (addresses below 16 MB) is DRAM at its own address and any higher address has no target.
- R2: A write with cfg_we high loads the field chosen by cfg_sel (0 DRAM base = wdata[15:0], 1 DRAM limit = wdata[15:0], 2 hole base = wdata[7:0], 3 hole offset = wdata[7:0], 4 hole enable = wdata[0]) and is used by requests from the next cycle on; writes with cfg_sel 5, 6 or 7 change nothing.
- R3: rsp_valid is high exactly in the cycle after a cycle with req_valid high.
- R4: rsp_target is 1 (DRAM) when request bits 39:24 lie between base and limit inclusive and the address is not in the hole.
- R5: With the hole enabled, an address whose bits 39:32 are zero and whose bits 31:24 are at or above the hole base gives rsp_target 2 (I/O), whatever the base and limit.
- R6: With the hole disabled, rsp_target is never 2 and no offset is applied.
- R7: For a DRAM address at or above 4 GB with the hole enabled, rsp_dram_addr is the address minus the hole offset shifted left by 24.
- R8: For any other DRAM address, rsp_dram_addr is the address minus the base shifted left by 24.
- R9: When rsp_target is 0 (no target) or 2 (I/O), rsp_dram_addr is 0; target value 3 never appears.
- R10: In a cycle after one with req_valid low, rsp_target and rsp_dram_addr keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration field select |
| cfg_wdata | input | 16 | Configuration write data |
| req_valid | input | 1 | Request address valid |
| req_addr | input | 40 | Physical request address |
| rsp_valid | output | 1 | Decision valid, one cycle after request |
| rsp_target | output | 2 | 0 no target, 1 DRAM, 2 I/O hole |
| rsp_dram_addr | output | 40 | DRAM-relative address, 0 unless DRAM |

## Verification
The assertions take for granted that the configuration is consistent when hoisting is on: limit equal to 4 GB plus the hole size above the base, and an offset computed from base and hole base, so that the relocated range lands inside the DRAM span. The bench only loads such settings (the two-node example and a node with a 2 GB base), plus one setting with the hole disabled, and never writes configuration in the same cycle as a request. Random addresses stay below 12 GB so that they cover the hole, the region just above 4 GB and the edges of the limit.

// File: rtl/dhd_pkg.sv
// Package: shared widths, target codes and configuration record of the
// DRAM hole remapping decoder. Assumes a byte address split into a
// granule index (above GRAN_LSB) and a 4 GB boundary at HOLE_HI.
package dhd_pkg;
    parameter int ADDR_W   = 40;
    parameter int GRAN_LSB = 24;
    parameter int HOLE_HI  = 32;
    parameter int SEL_W    = 3;

    localparam int GRAN_W = ADDR_W - GRAN_LSB;   // width of base/limit
    localparam int HOLE_W = HOLE_HI - GRAN_LSB;  // width of hole fields
    localparam int HIGH_W = ADDR_W - HOLE_HI;    // bits above 4 GB

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_DRAM = 2'd1,
        TGT_MMIO = 2'd2
    } target_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_BASE  = 3'd0,
        SEL_LIMIT = 3'd1,
        SEL_HBASE = 3'd2,
        SEL_HOFF  = 3'd3,
        SEL_HEN   = 3'd4
    } cfg_sel_e;

    typedef struct packed {
        logic [GRAN_W-1:0] base;
        logic [GRAN_W-1:0] limit;
        logic [HOLE_W-1:0] hole_base;
        logic [HOLE_W-1:0] hole_off;
        logic              hole_en;
    } node_cfg_t;

    // Widen a granule count to a byte address.
    function automatic logic [ADDR_W-1:0] gran_to_addr(input logic [GRAN_W-1:0] g);
        return {g, {GRAN_LSB{1'b0}}};
    endfunction
endpackage

// File: rtl/dhd_cfg_regs.sv
// Configuration store: holds base, limit, hole base, hole offset and
// hole enable. Assumes one field written per cycle; unknown selects
// are dropped. Synchronous active-low reset clears every field.
module dhd_cfg_regs
    import dhd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [GRAN_W-1:0] wdata,
    output node_cfg_t         cfg
);
    node_cfg_t cfg_q;
    node_cfg_t cfg_d;

    // Next-state for the field picked by the select.
    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (sel)
                SEL_BASE:  cfg_d.base      = wdata;
                SEL_LIMIT: cfg_d.limit     = wdata;
                SEL_HBASE: cfg_d.hole_base = wdata[HOLE_W-1:0];
                SEL_HOFF:  cfg_d.hole_off  = wdata[HOLE_W-1:0];
                SEL_HEN:   cfg_d.hole_en   = wdata[0];
                default:   cfg_d = cfg_q;
            endcase
        end
    end

    // Field storage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/dhd_window.sv
// Window classifier: tells whether an address lies inside the node's
// granule range, inside the I/O hole below 4 GB, and above 4 GB.
// Purely combinational; assumes limit is inclusive.
module dhd_window
    import dhd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  node_cfg_t         cfg,
    output logic              in_range,
    output logic              in_hole,
    output logic              above_4g
);
    logic [GRAN_W-1:0] gran;
    logic [HOLE_W-1:0] low_gran;
    logic [HIGH_W-1:0] high_bits;

    // Split the address into its granule, low-granule and high parts.
    always_comb begin
        gran      = addr[ADDR_W-1:GRAN_LSB];
        low_gran  = addr[HOLE_HI-1:GRAN_LSB];
        high_bits = addr[ADDR_W-1:HOLE_HI];
    end

    // Range and hole tests.
    always_comb begin
        above_4g = |high_bits;
        in_range = (gran >= cfg.base) && (gran <= cfg.limit);
        in_hole  = cfg.hole_en && !above_4g && (low_gran >= cfg.hole_base);
    end
endmodule

// File: rtl/dhd_translate.sv
// Translator: picks the target code and forms the DRAM-relative address.
// HOIST_EN = 0 builds a variant without the offset path. Assumes a hole
// address is never DRAM; non-DRAM results carry a zero address.
module dhd_translate
    import dhd_pkg::*;
#(
    parameter bit HOIST_EN = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  node_cfg_t         cfg,
    input  logic              in_range,
    input  logic              in_hole,
    input  logic              above_4g,
    output target_e           target,
    output logic [ADDR_W-1:0] dram_addr
);
    logic [ADDR_W-1:0] base_bytes;
    logic [ADDR_W-1:0] sub_amount;
    logic              use_offset;

    assign base_bytes = gran_to_addr(cfg.base);

    generate
        if (HOIST_EN) begin : g_hoist
            logic [ADDR_W-1:0] off_bytes;
            // Offset granule widened to a byte amount below 4 GB.
            always_comb begin
                off_bytes  = {{HIGH_W{1'b0}}, cfg.hole_off, {GRAN_LSB{1'b0}}};
                use_offset = cfg.hole_en && above_4g;
                sub_amount = use_offset ? off_bytes : base_bytes;
            end
        end else begin : g_plain
            // No relocation: always relative to the base.
            always_comb begin
                use_offset = 1'b0;
                sub_amount = base_bytes;
            end
        end
    endgenerate

    // Target priority: hole first, then the DRAM range, else nothing.
    always_comb begin
        if (in_hole) begin
            target    = TGT_MMIO;
            dram_addr = '0;
        end else if (in_range) begin
            target    = TGT_DRAM;
            dram_addr = addr - sub_amount;
        end else begin
            target    = TGT_NONE;
            dram_addr = '0;
        end
    end
endmodule

// File: rtl/dram_hole_decoder.sv
// Top: configuration store, window classifier and translator, with the
// decision registered one cycle after a valid request. Outputs hold
// their last result while no request arrives. Assumes configuration
// is consistent (limit widened by the hole when hoisting is on).
module dram_hole_decoder
    import dhd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [15:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic [39:0]       req_addr,
    output logic              rsp_valid,
    output logic [1:0]        rsp_target,
    output logic [39:0]       rsp_dram_addr
);
    node_cfg_t         cfg_q;
    logic              win_range;
    logic              win_hole;
    logic              win_high;
    target_e           dec_target;
    logic [ADDR_W-1:0] dec_addr;

    dhd_cfg_regs u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg   (cfg_q)
    );

    dhd_window u_win (
        .addr     (req_addr),
        .cfg      (cfg_q),
        .in_range (win_range),
        .in_hole  (win_hole),
        .above_4g (win_high)
    );

    dhd_translate #(.HOIST_EN(1'b1)) u_xlat (
        .addr      (req_addr),
        .cfg       (cfg_q),
        .in_range  (win_range),
        .in_hole   (win_hole),
        .above_4g  (win_high),
        .target    (dec_target),
        .dram_addr (dec_addr)
    );

    // Valid flag: one pulse per request, one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_valid <= 1'b0;
        else        rsp_valid <= req_valid;
    end

    // Decision register: load on request, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_target    <= TGT_NONE;
            rsp_dram_addr <= '0;
        end else if (req_valid) begin
            rsp_target    <= dec_target;
            rsp_dram_addr <= dec_addr;
        end
    end
endmodule

// File: rtl/dhd_checker.sv
// Checker: temporal properties of the decoder's ports, bound to the top.
// Assumes the bound configuration signals are the live register values.
module dhd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [39:0] req_addr,
    input logic        hole_en,
    input logic [7:0]  hole_base,
    input logic        rsp_valid,
    input logic [1:0]  rsp_target,
    input logic [39:0] rsp_dram_addr
);
    // R3: a request gives a valid response next cycle
    a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R3: no response without a request
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R10: idle cycles keep the previous decision
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_target) && $stable(rsp_dram_addr)));

    // R9: non-DRAM results carry a zero address
    a_r9_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_target != 2'd1) |-> (rsp_dram_addr == 40'd0));

    // R9: code 3 is never produced
    a_r9_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_target != 2'd3);

    // R6: hole disabled means no I/O decision
    a_r6_no_mmio_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hole_en) |=> (rsp_target != 2'd2));

    // R5: hole addresses always go to I/O
    a_r5_hole_to_mmio: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hole_en && (req_addr[39:32] == 8'd0) && (req_addr[31:24] >= hole_base))
        |=> (rsp_target == 2'd2));
endmodule

bind dram_hole_decoder dhd_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_addr      (req_addr),
    .hole_en       (cfg_q.hole_en),
    .hole_base     (cfg_q.hole_base),
    .rsp_valid     (rsp_valid),
    .rsp_target    (rsp_target),
    .rsp_dram_addr (rsp_dram_addr)
);

// File: tb/sim_dram_hole_decoder.sv
module sim_dram_hole_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        req_valid = 1'b0;
    logic [39:0] req_addr = 40'd0;
    logic        rsp_valid;
    logic [1:0]  rsp_target;
    logic [39:0] rsp_dram_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    longint m_base = 0, m_limit = 0, m_hbase = 0, m_hoff = 0;
    bit     m_en = 1'b0;
    bit          e_v = 1'b0;
    logic [1:0]  e_t = 2'd0;
    logic [39:0] e_a = 40'd0;

    always #2 clk = ~clk;   // 250 MHz

    dram_hole_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_target(rsp_target), .rsp_dram_addr(rsp_dram_addr)
    );

    localparam longint GRAN = longint'(1) << 24;
    localparam longint FOUR_G = longint'(1) << 32;

    task automatic model(input logic [39:0] a, output logic [1:0] t, output logic [39:0] d);
        longint ua = longint'(a);
        if (m_en && ua < FOUR_G && ua >= m_hbase * GRAN) begin
            t = 2'd2; d = 40'd0;
        end else if (ua >= m_base * GRAN && ua < (m_limit + 1) * GRAN) begin
            t = 2'd1;
            if (m_en && ua >= FOUR_G) d = 40'(ua - m_hoff * GRAN);
            else                      d = 40'(ua - m_base * GRAN);
        end else begin
            t = 2'd0; d = 40'd0;
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (rsp_valid !== e_v || rsp_target !== e_t || rsp_dram_addr !== e_a) begin
            errors++;
            $display("FAIL %s: got v=%0b t=%0d a=%h, expected v=%0b t=%0d a=%h",
                     tag, rsp_valid, rsp_target, rsp_dram_addr, e_v, e_t, e_a);
        end
    endtask

    // one clock: drive at negedge, check after the edge
    task automatic step(input bit v, input logic [39:0] a, input string tag);
        logic [1:0]  t;
        logic [39:0] d;
        @(negedge clk);
        req_valid = v; req_addr = a;
        e_v = v;
        if (v) begin
            model(a, t, d);
            e_t = t; e_a = d;
        end
        @(posedge clk); #1;
        compare(tag);
    endtask

    task automatic wcfg(input logic [2:0] s, input logic [15:0] w);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = w;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        e_v = 1'b0;
        case (s)
            3'd0: m_base  = longint'(w);
            3'd1: m_limit = longint'(w);
            3'd2: m_hbase = longint'(w[7:0]);
            3'd3: m_hoff  = longint'(w[7:0]);
            3'd4: m_en    = w[0];
            default: ;
        endcase
        compare("R10 hold during config write");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        e_v = 0; e_t = 0; e_a = 0;
        compare("R1 in reset");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        compare("R1 first cycle after reset");

        // R1: cleared configuration
        step(1, 40'h00_0012_3456, "R1 default granule 0 DRAM");
        step(1, 40'h00_0100_0000, "R1 default above granule 0");
        step(0, 40'h00_0000_0000, "R10 idle hold");
        step(0, 40'h00_0000_0000, "R3 no spurious valid");

        // R2 example node 0
        wcfg(3'd0, 16'h0000);
        wcfg(3'd1, 16'h013F);
        wcfg(3'd2, 16'h00C0);
        wcfg(3'd3, 16'h0040);
        wcfg(3'd4, 16'h0001);
        step(1, 40'h00_0010_0000, "R4 low DRAM");
        step(1, 40'h00_BFFF_FFFF, "R8 just below hole");
        step(1, 40'h00_C000_0000, "R5 hole bottom");
        step(1, 40'h00_FFFF_FFFF, "R5 hole top");
        step(1, 40'h01_0000_0000, "R7 first relocated byte");
        step(1, 40'h01_3FFF_FFFF, "R7 limit byte");
        step(1, 40'h01_4000_0000, "R9 above limit");
        step(0, 40'h01_0000_0000, "R10 hold");

        // R2: ignored selects
        wcfg(3'd5, 16'hFFFF);
        wcfg(3'd6, 16'h1234);
        wcfg(3'd7, 16'h0000);
        step(1, 40'h01_0000_0000, "R2 ignored select left config");
        step(1, 40'h00_C000_0000, "R2 ignored select hole kept");

        // R6: second node, hole disabled
        wcfg(3'd0, 16'h0140);
        wcfg(3'd1, 16'h023F);
        wcfg(3'd2, 16'h0000);
        wcfg(3'd3, 16'h0000);
        wcfg(3'd4, 16'h0000);
        step(1, 40'h01_4000_0000, "R8 node base");
        step(1, 40'h02_3FFF_FFFF, "R8 node limit");
        step(1, 40'h02_4000_0000, "R9 past limit");
        step(1, 40'h00_C000_0000, "R6 no hole when disabled");
        step(1, 40'h01_3FFF_FFFF, "R9 below base");

        // R7 node with 2 GB base
        wcfg(3'd0, 16'h0080);
        wcfg(3'd1, 16'h017F);
        wcfg(3'd2, 16'h00C0);
        wcfg(3'd3, 16'h00C0);
        wcfg(3'd4, 16'h0001);
        step(1, 40'h00_8000_0000, "R8 base offset");
        step(1, 40'h00_7FFF_FFFF, "R9 below base");
        step(1, 40'h00_BF00_0000, "R4 last granule below hole");
        step(1, 40'h01_0000_0000, "R7 relocated with base");
        step(1, 40'h01_7FFF_FFFF, "R7 limit");
        step(1, 40'h00_1000_0000, "R9 low no target");

        // random mix against the model
        for (int i = 0; i < 400; i++) begin
            logic [39:0] a;
            a = {8'($urandom_range(0, 2)), 32'($urandom)};
            if (i % 50 == 10) begin
                wcfg(3'd4, 16'($urandom_range(0, 1)));
            end
            step(($urandom_range(0, 3) != 0), a, "R4 random mix");
        end

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule